// File: doc/BRIEF.md
# Read-Window Termination Gate for a Burst SRAM

This block sits on the device side of a double-data-rate burst SRAM. It watches the command stream that is sampled on each rising K edge. From that stream it produces one enable for on-die termination of the shared data bus. Termination stays on while the bus is idle or carrying write data. It turns off for exactly the half-cycles in which the device itself drives read data, and then turns back on.

Time is counted in half-cycle ticks. A clock at twice the K rate advances the block, and a phase flag marks the ticks that line up with a rising K edge. Every change of the enable therefore lands on a half-cycle boundary.

Two static configuration inputs set the burst length (2 or 4 words) and the read latency (2.0 or 2.5 K cycles). The interface is plain control: there is no data payload, so the ports carry no valid/ready handshake and no back-pressure.

Top module: `sram_odt_ctrl`

## Requirements
- R1: A synchronous reset drives `odt_en` to 1 and `cmd_err` to 0 on the next tick and discards every pending read window, so a read sampled before reset never turns termination off afterwards.
- R2: A command is sampled only on a tick edge where `k_rise` is 1. A command present on any other edge has no effect on `odt_en` or `cmd_err`.
- R3: The read latency in ticks is L = 4 when `cfg_lat25` = 0 and L = 5 when `cfg_lat25` = 1. For a read accepted on tick edge e, `odt_en` is 0 after edge e+L.
- R4: The off window of one read lasts B ticks after that first edge, with B = 2 when `cfg_burst4` = 0 and B = 4 when `cfg_burst4` = 1. It therefore covers edges e+L through e+L+B-1, and `odt_en` returns to 1 after the window unless another window covers that tick.
- R5: Read windows that touch or overlap merge into one continuous off period, with no single-tick re-enable between them.
- R6: Write and NOP commands never turn termination off.
- R7: With `cfg_burst4` = 1, the K edge that follows an accepted read or write is blocked. A command on the blocked edge is ignored. If that command is a read or a write, `cmd_err` is 1 for the one tick after that edge.
- R8: With `cfg_burst4` = 0, every K edge accepts a command and `cmd_err` stays 0.
- R9: `cmd` encodes 2'b01 as read, 2'b10 as write, and 2'b00 or 2'b11 as NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the K rate; one edge per half-cycle tick |
| rst | input | 1 | Synchronous reset, active high |
| k_rise | input | 1 | Phase flag: 1 on the edge aligned with a rising K edge |
| cmd | input | 2 | Command sampled on K-aligned edges (R9 encoding) |
| cfg_burst4 | input | 1 | Static: 1 selects 4-word bursts, 0 selects 2-word bursts |
| cfg_lat25 | input | 1 | Static: 1 selects 2.5-cycle latency, 0 selects 2.0 |
| odt_en | output | 1 | Termination enable, 0 during read data windows |
| cmd_err | output | 1 | One-tick pulse for a read or write on a blocked K edge |

## Verification
For a read sampled on edge e, `odt_en` falls after edge e+L, with L equal to 4 or 5. It stays low through edge e+L+B-1. `cmd_err` is due after the same edge that samples the blocked command.

The bench records the absolute edge index of every accepted read. It sets up inputs half a period before each edge and reads both outputs half a period after it. Each edge is then compared with the value that the edge-index arithmetic predicts for that edge. This comparison covers all four configurations, with directed and random command mixes.

// File: rtl/sram_odt_pkg.sv
package sram_odt_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_READ = 2'b01,
    CMD_WRIT = 2'b10,
    CMD_NOP2 = 2'b11
  } sram_cmd_e;

  function automatic logic is_burst_cmd(input logic [1:0] c);
    return (c == CMD_READ) || (c == CMD_WRIT);
  endfunction

endpackage

// File: rtl/sram_odt_cmd_gate.sv
module sram_odt_cmd_gate
  import sram_odt_pkg::*;
(
  input  logic       clk2x,
  input  logic       rst,
  input  logic       k_rise,
  input  logic [1:0] cmd,
  input  logic       cfg_burst4,
  output logic       rd_start,
  output logic       cmd_err
);

  logic blk_q;
  logic err_q;
  logic is_rd;
  logic is_burst;

  always_comb begin
    is_rd    = (cmd == CMD_READ);
    is_burst = is_burst_cmd(cmd);
    rd_start = k_rise && !blk_q && is_rd;
  end

  always_ff @(posedge clk2x) begin
    if (rst) begin
      blk_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (k_rise) begin
        if (blk_q) begin
          blk_q <= 1'b0;
          err_q <= is_burst;
        end else begin
          blk_q <= cfg_burst4 && is_burst;
        end
      end
    end
  end

  assign cmd_err = err_q;

endmodule

// File: rtl/sram_odt_sched.sv
module sram_odt_sched #(
  parameter int LAT_BASE_HALF = 4,
  parameter int BURST_SHORT   = 2,
  parameter int BURST_LONG    = 4
) (
  input  logic clk2x,
  input  logic rst,
  input  logic rd_start,
  input  logic cfg_burst4,
  input  logic cfg_lat25,
  output logic off_now
);

  localparam int W  = LAT_BASE_HALF + BURST_LONG;
  localparam int CW = $clog2(W + 2) + 1;

  logic [W-1:0]  sched_q;
  logic [W-1:0]  win;
  logic [CW-1:0] lat_h;
  logic [CW-1:0] bl_len;
  logic          off_q;

  always_comb begin
    lat_h  = CW'(LAT_BASE_HALF) + CW'(cfg_lat25);
    bl_len = cfg_burst4 ? CW'(BURST_LONG) : CW'(BURST_SHORT);
  end

  // bit j of the schedule stands for the tick j+1 edges ahead
  for (genvar j = 0; j < W; j++) begin : g_win
    assign win[j] = rd_start && (CW'(j + 1) >= lat_h) && (CW'(j + 1) < lat_h + bl_len);
  end

  always_ff @(posedge clk2x) begin
    if (rst) begin
      sched_q <= '0;
      off_q   <= 1'b0;
    end else begin
      off_q   <= sched_q[0];
      sched_q <= {1'b0, sched_q[W-1:1]} | win;
    end
  end

  assign off_now = off_q;

endmodule

// File: rtl/sram_odt_ctrl.sv
module sram_odt_ctrl #(
  parameter int LAT_BASE_HALF = 4,
  parameter int BURST_SHORT   = 2,
  parameter int BURST_LONG    = 4
) (
  input  logic       clk2x,
  input  logic       rst,
  input  logic       k_rise,
  input  logic [1:0] cmd,
  input  logic       cfg_burst4,
  input  logic       cfg_lat25,
  output logic       odt_en,
  output logic       cmd_err
);

  logic rd_start;
  logic off_now;

  sram_odt_cmd_gate u_gate (
    .clk2x      (clk2x),
    .rst        (rst),
    .k_rise     (k_rise),
    .cmd        (cmd),
    .cfg_burst4 (cfg_burst4),
    .rd_start   (rd_start),
    .cmd_err    (cmd_err)
  );

  sram_odt_sched #(
    .LAT_BASE_HALF (LAT_BASE_HALF),
    .BURST_SHORT   (BURST_SHORT),
    .BURST_LONG    (BURST_LONG)
  ) u_sched (
    .clk2x      (clk2x),
    .rst        (rst),
    .rd_start   (rd_start),
    .cfg_burst4 (cfg_burst4),
    .cfg_lat25  (cfg_lat25),
    .off_now    (off_now)
  );

  assign odt_en = ~off_now;

endmodule

// File: rtl/sram_odt_chk.sv
module sram_odt_chk (
  input logic       clk2x,
  input logic       rst,
  input logic       k_rise,
  input logic [1:0] cmd,
  input logic       cfg_burst4,
  input logic       odt_en,
  input logic       cmd_err
);

  localparam int MAX_REACH = 8;

  logic [3:0] since_rd;

  always_ff @(posedge clk2x) begin
    if (rst) since_rd <= 4'hF;
    else if (k_rise && cmd == 2'b01) since_rd <= 4'h0;
    else if (since_rd != 4'hF) since_rd <= since_rd + 4'h1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk2x) rst |=> (odt_en && !cmd_err));

  // R5
  no_lone_off_tick_chk: assert property (@(posedge clk2x) disable iff (rst)
    $fell(odt_en) |=> !odt_en);

  // R7
  err_on_k_edge_chk: assert property (@(posedge clk2x) disable iff (rst)
    cmd_err |-> $past(k_rise));

  // R8
  no_err_short_burst_chk: assert property (@(posedge clk2x) disable iff (rst)
    !cfg_burst4 |=> !cmd_err);

  // R6
  off_needs_recent_read_chk: assert property (@(posedge clk2x) disable iff (rst)
    !odt_en |-> (since_rd <= 4'(MAX_REACH)));

endmodule

bind sram_odt_ctrl sram_odt_chk u_chk (.*);

// File: tb/tb_sram_odt_ctrl.sv
module tb_sram_odt_ctrl;

  logic       clk2x = 1'b0;
  logic       rst = 1'b1;
  logic       k_rise = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic       cfg_burst4 = 1'b0;
  logic       cfg_lat25 = 1'b0;
  logic       odt_en;
  logic       cmd_err;

  always #10 clk2x = ~clk2x;

  sram_odt_ctrl dut (
    .clk2x      (clk2x),
    .rst        (rst),
    .k_rise     (k_rise),
    .cmd        (cmd),
    .cfg_burst4 (cfg_burst4),
    .cfg_lat25  (cfg_lat25),
    .odt_en     (odt_en),
    .cmd_err    (cmd_err)
  );

  int    total = 0;
  int    bad = 0;
  int    cur = 0;
  int    rd_q[16];
  int    rd_n = 0;
  bit    blk = 0;
  string req = "R3";
  bit    done = 0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s edge=%0d actual=%0d expected=%0d", r, cur, act, exp);
    end
  endtask

  function automatic bit covered(input int e);
    int lat = cfg_lat25 ? 5 : 4;
    int bl  = cfg_burst4 ? 4 : 2;
    int n   = (rd_n < 16) ? rd_n : 16;
    for (int i = 0; i < n; i++) begin
      int s = rd_q[(rd_n - 1 - i) % 16];
      if (e >= s + lat && e <= s + lat + bl - 1) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic tick(input logic [1:0] c);
    bit ph = (cur % 2 == 0);
    bit e_err = 0;
    bit e_odt;
    k_rise = ph;
    cmd = c;
    if (ph) begin
      if (blk) begin
        blk = 0;
        e_err = (c == 2'b01 || c == 2'b10);
      end else begin
        if (c == 2'b01) begin
          rd_q[rd_n % 16] = cur;
          rd_n++;
        end
        if (cfg_burst4 && (c == 2'b01 || c == 2'b10)) blk = 1;
      end
    end
    @(posedge clk2x);
    @(negedge clk2x);
    e_odt = !covered(cur);
    chk(odt_en == e_odt, req, int'(odt_en), int'(e_odt));
    chk(cmd_err == e_err, cfg_burst4 ? "R7" : "R8", int'(cmd_err), int'(e_err));
    cur++;
  endtask

  task automatic kcmd(input logic [1:0] c);
    if (cur % 2 != 0) tick(2'b00);
    tick(c);
    tick(2'b00);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    k_rise = 1'b0;
    cmd = 2'b00;
    repeat (3) @(negedge clk2x);
    rst = 1'b0;
    rd_n = 0;
    blk = 0;
    cur = 0;
    chk(odt_en == 1'b1, "R1", int'(odt_en), 1);
    chk(cmd_err == 1'b0, "R1", int'(cmd_err), 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk2x);
    for (int cfg = 0; cfg < 4; cfg++) begin
      cfg_burst4 = cfg[1];
      cfg_lat25  = cfg[0];
      do_reset();
      // R6: idle and writes keep termination on
      req = "R6";
      repeat (6) tick(2'b00);
      kcmd(2'b10);
      kcmd(2'b11);
      repeat (6) tick(2'b00);
      // R3 R4: single read, latency and window length
      req = "R3 R4";
      kcmd(2'b01);
      repeat (10) tick(2'b00);
      // R6 then R3: read right behind a write
      req = "R6 R3";
      kcmd(2'b10);
      if (cfg_burst4) kcmd(2'b00);
      kcmd(2'b01);
      repeat (10) tick(2'b00);
      // R5: back-to-back reads at the densest legal spacing
      req = "R5";
      repeat (4) begin
        kcmd(2'b01);
        if (cfg_burst4) kcmd(2'b00);
      end
      repeat (10) tick(2'b00);
      // R7: command on the blocked edge; R8 when short bursts accept it
      req = "R7 R8";
      kcmd(2'b01);
      kcmd(2'b01);
      kcmd(2'b10);
      kcmd(2'b10);
      repeat (10) tick(2'b00);
      // R2: reads on off-phase edges are ignored
      req = "R2";
      repeat (6) begin
        tick(2'b00);
        tick(2'b01);
      end
      repeat (10) tick(2'b00);
      // R9: random mixes of all codes on every edge
      req = "R9 R5";
      repeat (400) tick(2'($urandom_range(0, 3)));
      repeat (10) tick(2'b00);
      // R1: reset in the middle of a pending window
      req = "R1";
      kcmd(2'b01);
      tick(2'b00);
      do_reset();
      repeat (12) tick(2'b00);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule